// File: doc/BRIEF.md
# Flash Self-Programming Write Controller

This block lets a processor rewrite its own on-chip flash through a small byte-wide register interface. Software sets a 22-bit table pointer from three byte registers and puts a byte in the table latch. A table-write strobe then copies that byte into a 64-byte holding buffer and advances the pointer. A start command launches one of two operations. A row erase sets every byte of a 1024-byte block to FFh. A row program copies the holding buffer into one 64-byte flash row.

The start command is guarded twice. The write-enable bit must already be set, and the bytes 55h and AAh must have been written to the key register, in that order, with no other register write in between. A start that fails either check does nothing and sets a sticky error flag. An accepted operation raises `busy_o` for a fixed number of cycles, and the processor stalls while it is high. During that time the sequencer writes the flash one byte per cycle. A table-read strobe copies the flash byte at the pointer into the table latch.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: A start (CTRL bit 0 written as 1) is accepted only if the last two register writes were 55h and then AAh to KEY (address 5). A wrong byte or byte order, or any other register write after the key, disarms the check. Writing 55h to KEY always begins a new key.
- R2: A start is accepted only if the write-enable bit (CTRL bit 1) was already set before the write that carries the start bit.
- R3: A rejected start leaves `busy_o` low and sets `err_o`. `err_o` stays set until a CTRL write with bit 3 set clears it.
- R4: With the erase-select bit (CTRL bit 2) set, the operation writes FFh to every byte of the 1024-byte-aligned block that contains the pointer. All other flash bytes keep their values.
- R5: With the erase-select bit clear, the operation copies holding-buffer entries 0..63 into the 64-byte-aligned row that holds the address of the most recent table-write.
- R6: A table-write stores the table latch (address 3) into buffer entry pointer[5:0], then increments the 22-bit pointer, which wraps from 3FFFFFh to 0. The pointer bytes are low = address 0, high = address 1, upper = address 2, and the upper byte keeps bits [5:0].
- R7: `busy_o` goes high in the cycle after an accepted start and stays high for exactly BUSY_CYC cycles. `ctrl_o[0]` reads 1 during the operation and clears when it ends.
- R8: Every holding-buffer entry returns to FFh when a program completes.
- R9: While `busy_o` is high, register writes, table-writes and table-reads have no effect.
- R10: A table-read loads the flash byte at pointer[10:0] into the table latch and leaves the pointer unchanged.
- R11: After reset, `busy_o`, `err_o`, `ctrl_o`, `ptr_o` and `tablat_o` are 0, and every flash byte is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select: 0 ptr low, 1 ptr high, 2 ptr upper, 3 table latch, 4 control, 5 key |
| reg_wdata_i | input | 8 | Register write data |
| tblwt_i | input | 1 | Table-write strobe (latch to buffer, pointer +1) |
| tblrd_i | input | 1 | Table-read strobe (flash byte to latch) |
| busy_o | output | 1 | Operation in progress, processor stall |
| err_o | output | 1 | Sticky rejected-start flag |
| ctrl_o | output | 3 | Control state: [0] start, [1] write enable, [2] erase select |
| ptr_o | output | 22 | Table pointer |
| tablat_o | output | 8 | Table latch |

## Verification
The hardest case to reach is a start that looks almost valid: keys in the right order with one stray write between them and the start, or a write-enable bit that only arrives together with the start bit. A table of key pairs, write-enable settings and stray-write flags drives the full write sequence for each case and checks whether `busy_o` or `err_o` follows. Buffer reset is seen only indirectly, so a second program with a single table-write follows a full-row program, and the untouched bytes of the new row are read back.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam logic [2:0] ADR_PTR_L  = 3'd0;
  localparam logic [2:0] ADR_PTR_H  = 3'd1;
  localparam logic [2:0] ADR_PTR_U  = 3'd2;
  localparam logic [2:0] ADR_TABLAT = 3'd3;
  localparam logic [2:0] ADR_CTRL   = 3'd4;
  localparam logic [2:0] ADR_KEY    = 3'd5;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam logic [7:0] ERASED     = 8'hFF;

  localparam int CTRL_START = 0;
  localparam int CTRL_WEN   = 1;
  localparam int CTRL_ERASE = 2;
  localparam int CTRL_CLR   = 3;

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_HALF  = 2'd1,
    KEY_ARMED = 2'd2
  } key_st_e;
endpackage

// File: rtl/fsp_key_check.sv
module fsp_key_check
  import fsp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] data_i,
  output logic       armed_o
);
  key_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= KEY_IDLE;
    end else if (wr_i) begin
      if (addr_i == ADR_KEY) begin
        if (data_i == KEY_FIRST)                          st_q <= KEY_HALF;
        else if (st_q == KEY_HALF && data_i == KEY_SECOND) st_q <= KEY_ARMED;
        else                                              st_q <= KEY_IDLE;
      end else begin
        st_q <= KEY_IDLE;  // any other write, start included, disarms
      end
    end
  end

  assign armed_o = (st_q == KEY_ARMED);
endmodule

// File: rtl/fsp_hold_buf.sv
module fsp_hold_buf #(
  parameter int ROW_BYTES = 64,
  localparam int RW = $clog2(ROW_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [RW-1:0] wr_idx_i,
  input  logic [7:0]    wr_data_i,
  input  logic          clr_i,
  input  logic [RW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem_q [ROW_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ROW_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (clr_i) begin
      for (int i = 0; i < ROW_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (wr_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/fsp_flash_array.sv
module fsp_flash_array #(
  parameter int AW = 11,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= 8'hFF;
    end else if (we_i) begin
      cell_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = cell_q[raddr_i];
endmodule

// File: rtl/fsp_seq.sv
module fsp_seq #(
  parameter int AW        = 11,
  parameter int ROW_BYTES = 64,
  parameter int BLK_BYTES = 1024,
  parameter int BUSY_CYC  = 1040,
  localparam int RW = $clog2(ROW_BYTES),
  localparam int BW = $clog2(BLK_BYTES),
  localparam int CW = $clog2(BUSY_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          erase_i,
  input  logic [AW-1:0] blk_addr_i,
  input  logic [AW-1:0] row_addr_i,
  input  logic [7:0]    buf_data_i,
  output logic [RW-1:0] buf_idx_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          prog_done_o,
  output logic          erase_op_o,
  output logic          fl_we_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_wdata_o
);
  localparam logic [CW-1:0] LAST    = CW'(BUSY_CYC - 1);
  localparam logic [CW-1:0] ROW_LEN = CW'(ROW_BYTES);
  localparam logic [CW-1:0] BLK_LEN = CW'(BLK_BYTES);

  logic          busy_q, erase_q;
  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i) begin
      busy_q  <= 1'b1;
      erase_q <= erase_i;
      cnt_q   <= '0;
      base_q  <= erase_i ? {blk_addr_i[AW-1:BW], BW'(0)}
                         : {row_addr_i[AW-1:RW], RW'(0)};
    end
  end

  assign len         = erase_q ? BLK_LEN : ROW_LEN;
  assign busy_o      = busy_q;
  assign done_o      = busy_q && (cnt_q == LAST);
  assign prog_done_o = done_o && !erase_q;
  assign erase_op_o  = erase_q;
  assign buf_idx_o   = cnt_q[RW-1:0];
  assign fl_we_o     = busy_q && (cnt_q < len);
  assign fl_addr_o   = base_q + AW'(cnt_q);
  assign fl_wdata_o  = erase_q ? 8'hFF : buf_data_i;
endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import fsp_pkg::*;
#(
  parameter int PTR_W     = 22,
  parameter int AW        = 11,
  parameter int ROW_BYTES = 64,
  parameter int BLK_BYTES = 1024,
  parameter int BUSY_CYC  = 1040,
  localparam int RW = $clog2(ROW_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  input  logic             tblwt_i,
  input  logic             tblrd_i,
  output logic             busy_o,
  output logic             err_o,
  output logic [2:0]       ctrl_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [7:0]       tablat_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       tablat_q;
  logic [AW-1:0]    last_wr_q;
  logic             wen_q, erase_q, start_q, err_q;

  logic             busy, done, prog_done, erase_op, key_armed;
  logic             acc_wr, acc_tw, acc_tr, ctrl_wr, start_req, start_go, start_bad;
  logic [RW-1:0]    buf_idx;
  logic [7:0]       buf_data, fl_rdata, fl_wdata;
  logic             fl_we;
  logic [AW-1:0]    fl_addr;

  assign acc_wr    = reg_we_i && !busy;
  assign acc_tw    = tblwt_i && !busy;
  assign acc_tr    = tblrd_i && !busy;
  assign ctrl_wr   = acc_wr && (reg_addr_i == ADR_CTRL);
  assign start_req = ctrl_wr && reg_wdata_i[CTRL_START];
  assign start_go  = start_req && wen_q && key_armed;
  assign start_bad = start_req && !start_go;

  fsp_key_check u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (acc_wr),
    .addr_i  (reg_addr_i),
    .data_i  (reg_wdata_i),
    .armed_o (key_armed)
  );

  fsp_hold_buf #(.ROW_BYTES(ROW_BYTES)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (acc_tw),
    .wr_idx_i  (ptr_q[RW-1:0]),
    .wr_data_i (tablat_q),
    .clr_i     (prog_done),
    .rd_idx_i  (buf_idx),
    .rd_data_o (buf_data)
  );

  fsp_seq #(
    .AW(AW), .ROW_BYTES(ROW_BYTES), .BLK_BYTES(BLK_BYTES), .BUSY_CYC(BUSY_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_go),
    .erase_i     (reg_wdata_i[CTRL_ERASE]),
    .blk_addr_i  (ptr_q[AW-1:0]),
    .row_addr_i  (last_wr_q),
    .buf_data_i  (buf_data),
    .buf_idx_o   (buf_idx),
    .busy_o      (busy),
    .done_o      (done),
    .prog_done_o (prog_done),
    .erase_op_o  (erase_op),
    .fl_we_o     (fl_we),
    .fl_addr_o   (fl_addr),
    .fl_wdata_o  (fl_wdata)
  );

  fsp_flash_array #(.AW(AW)) u_flash (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (fl_we),
    .waddr_i (fl_addr),
    .wdata_i (fl_wdata),
    .raddr_i (ptr_q[AW-1:0]),
    .rdata_o (fl_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      tablat_q  <= '0;
      last_wr_q <= '0;
    end else if (acc_tw) begin
      ptr_q     <= ptr_q + 1'b1;
      last_wr_q <= ptr_q[AW-1:0];
    end else if (acc_tr) begin
      tablat_q <= fl_rdata;
    end else if (acc_wr) begin
      unique case (reg_addr_i)
        ADR_PTR_L:  ptr_q[7:0]        <= reg_wdata_i;
        ADR_PTR_H:  ptr_q[15:8]       <= reg_wdata_i;
        ADR_PTR_U:  ptr_q[PTR_W-1:16] <= reg_wdata_i[PTR_W-17:0];
        ADR_TABLAT: tablat_q          <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q   <= 1'b0;
      erase_q <= 1'b0;
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (done) start_q <= 1'b0;
      if (ctrl_wr) begin
        wen_q   <= reg_wdata_i[CTRL_WEN];
        erase_q <= reg_wdata_i[CTRL_ERASE];
        start_q <= start_go;
      end
      if (start_bad)                            err_q <= 1'b1;
      else if (ctrl_wr && reg_wdata_i[CTRL_CLR]) err_q <= 1'b0;
    end
  end

  assign busy_o   = busy;
  assign err_o    = err_q;
  assign ctrl_o   = {erase_q, wen_q, start_q};
  assign ptr_o    = ptr_q;
  assign tablat_o = tablat_q;
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int PTR_W    = 22,
  parameter int BUSY_CYC = 1040
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic [7:0]       reg_wdata_i,
  input logic             busy_i,
  input logic             err_i,
  input logic             armed_i,
  input logic             wen_i,
  input logic             fl_we_i,
  input logic [7:0]       fl_wdata_i,
  input logic             erase_op_i,
  input logic             tw_i,
  input logic [PTR_W-1:0] ptr_i
);
  localparam int CW = $clog2(BUSY_CYC + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_i) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R1 R2: an operation starts only from an armed key and an enabled write
  p_start_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(armed_i && wen_i));

  // R3
  p_err_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !(reg_we_i && !busy_i && reg_addr_i == 3'd4 && reg_wdata_i[3])) |=> err_i);

  // R4
  p_erase_ff_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_we_i && erase_op_i) |-> (fl_wdata_i == 8'hFF));

  // R6
  p_ptr_inc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tw_i |=> (ptr_i == $past(ptr_i) + 1'b1));

  // R7
  p_busy_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (run_q == CW'(BUSY_CYC)));

  // R9: flash is written only during an operation
  p_no_idle_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_we_i |-> busy_i);
endmodule

bind flash_selfprog_ctrl fsp_checker #(.PTR_W(PTR_W), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .busy_i      (busy_o),
  .err_i       (err_o),
  .armed_i     (key_armed),
  .wen_i       (wen_q),
  .fl_we_i     (fl_we),
  .fl_wdata_i  (fl_wdata),
  .erase_op_i  (erase_op),
  .tw_i        (acc_tw),
  .ptr_i       (ptr_q)
);

// File: tb/flash_selfprog_ctrl_tb_top.sv
module flash_selfprog_ctrl_tb_top;
  localparam int BUSY_CYC = 1040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        tblwt = 1'b0;
  logic        tblrd = 1'b0;
  logic        busy, err;
  logic [2:0]  ctrl;
  logic [21:0] ptr;
  logic [7:0]  tablat;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_selfprog_ctrl #(.BUSY_CYC(BUSY_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .tblwt_i(tblwt), .tblrd_i(tblrd),
    .busy_o(busy), .err_o(err), .ctrl_o(ctrl), .ptr_o(ptr), .tablat_o(tablat)
  );

  // {key1[18:11], key2[10:3], wen[2], stray_write[1], accept[0]}
  localparam logic [18:0] VEC [7] = '{
    {8'h55, 8'hAA, 1'b1, 1'b0, 1'b1},
    {8'hAA, 8'h55, 1'b1, 1'b0, 1'b0},
    {8'h55, 8'h55, 1'b1, 1'b0, 1'b0},
    {8'h55, 8'hAA, 1'b0, 1'b0, 1'b0},
    {8'h12, 8'hAA, 1'b1, 1'b0, 1'b0},
    {8'h55, 8'hAA, 1'b1, 1'b1, 1'b0},
    {8'h55, 8'hAA, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_wt();
    @(negedge clk); tblwt = 1'b1;
    @(negedge clk); tblwt = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); tblrd = 1'b1;
    @(negedge clk); tblrd = 1'b0;
  endtask

  task automatic set_ptr(input logic [21:0] p);
    wr(3'd0, p[7:0]); wr(3'd1, p[15:8]); wr(3'd2, {2'b00, p[21:16]});
  endtask

  task automatic rd_flash(input logic [21:0] p, output logic [7:0] v);
    set_ptr(p);
    pulse_rd();
    v = tablat;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic unlock_start(input logic [7:0] bits);
    wr(3'd5, 8'h55); wr(3'd5, 8'hAA); wr(3'd4, bits | 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 err", err, 0);
    chk("R11 ctrl", ctrl, 0);
    chk("R11 ptr", ptr, 0);
    chk("R11 tablat", tablat, 0);
    rd_flash(22'h0, v);
    chk("R11 flash erased", v, 8'hFF);

    // R1 R2 R3 R7: key / enable gate table
    foreach (VEC[k]) begin
      wr(3'd4, {4'b0000, 1'b1, 1'b1, VEC[k][2], 1'b0});
      wr(3'd5, VEC[k][18:11]);
      wr(3'd5, VEC[k][10:3]);
      if (VEC[k][1]) wr(3'd3, 8'h00);
      wr(3'd4, 8'h07);
      chk($sformatf("R1 R2 vec%0d busy", k), busy, VEC[k][0]);
      chk($sformatf("R3 vec%0d err", k), err, !VEC[k][0]);
      if (VEC[k][0]) begin
        chk("R7 start bit set", ctrl[0], 1);
        wait_idle(n);
        chk("R7 busy length", n, BUSY_CYC);
        chk("R7 start self-clear", ctrl[0], 0);
      end
    end

    // R3 sticky error and clear
    wr(3'd4, 8'h03);
    chk("R3 set w/o key", err, 1);
    chk("R3 no op", busy, 0);
    wr(3'd4, 8'h02);
    chk("R3 sticky", err, 1);
    wr(3'd4, 8'h0A);
    chk("R3 cleared", err, 0);

    // R6 R5 R7: full row program at 0x80
    set_ptr(22'h80);
    for (int i = 0; i < 64; i++) begin
      wr(3'd3, 8'(i) ^ 8'h5A);
      pulse_wt();
    end
    chk("R6 ptr incremented", ptr, 22'hC0);
    wr(3'd4, 8'h02);
    unlock_start(8'h02);
    chk("R5 program accepted", busy, 1);
    wait_idle(n);
    chk("R7 program length", n, BUSY_CYC);
    chk("R7 ctrl after program", ctrl, 3'b010);
    rd_flash(22'h80, v);  chk("R5 byte0", v, 8'h5A);
    rd_flash(22'h81, v);  chk("R5 byte1", v, 8'h5B);
    rd_flash(22'h9F, v);  chk("R5 byte31", v, 8'h1F ^ 8'h5A);
    rd_flash(22'hBF, v);  chk("R5 byte63", v, 8'h3F ^ 8'h5A);
    rd_flash(22'hC0, v);  chk("R5 next row untouched", v, 8'hFF);
    rd_flash(22'h7F, v);  chk("R5 prev row untouched", v, 8'hFF);
    chk("R10 ptr unchanged by read", ptr, 22'h7F);

    // R8: buffer cleared after program
    set_ptr(22'h100);
    wr(3'd3, 8'h11);
    pulse_wt();
    wr(3'd4, 8'h02);
    unlock_start(8'h02);
    wait_idle(n);
    rd_flash(22'h100, v); chk("R8 written byte", v, 8'h11);
    rd_flash(22'h101, v); chk("R8 buffer reset byte1", v, 8'hFF);
    rd_flash(22'h13F, v); chk("R8 buffer reset byte63", v, 8'hFF);

    // row in second erase block, with writes during busy (R9)
    set_ptr(22'h400);
    wr(3'd3, 8'h77);
    pulse_wt();
    wr(3'd4, 8'h02);
    unlock_start(8'h02);
    wr(3'd0, 8'h55);
    wr(3'd3, 8'h99);
    pulse_wt();
    pulse_rd();
    chk("R9 ptr ignored in busy", ptr, 22'h401);
    chk("R9 tablat ignored in busy", tablat, 8'h77);
    wait_idle(n);
    rd_flash(22'h400, v); chk("R5 block1 row", v, 8'h77);

    // R4 erase block containing 0x123
    set_ptr(22'h123);
    wr(3'd4, 8'h06);
    unlock_start(8'h06);
    chk("R4 erase accepted", busy, 1);
    wait_idle(n);
    chk("R4 ptr kept", ptr, 22'h123);
    rd_flash(22'h80, v);  chk("R4 erased 0x80", v, 8'hFF);
    rd_flash(22'h100, v); chk("R4 erased 0x100", v, 8'hFF);
    rd_flash(22'h400, v); chk("R4 other block kept", v, 8'h77);

    // R6 upper byte width and wrap
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    chk("R6 22-bit ptr", ptr, 22'h3FFFFF);
    pulse_wt();
    chk("R6 ptr wrap", ptr, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule